// File: doc/BRIEF.md
# Hard-Decision Block Viterbi Decoder

This block decodes a rate 1/2 convolutional code with constraint length 3. The generator taps are 111 and 101. It works on fixed-length blocks. Each received channel symbol is two hard-decided bits, offered on a valid/ready input. For every symbol the block does three things:

- it forms Hamming branch metrics;
- it updates four path metrics through an add-compare-select step per trellis state;
- it writes one survivor decision bit per state into a per-block survivor store.

Once a block of `BLOCK_LEN` symbols has arrived, the input closes. A traceback pass then walks the survivor store from the last stage back to the first. It starts in the all-zero state and handles one stage per clock. The recovered bits land in a reorder buffer. They are then streamed out in their original time order on a valid/ready output.

The sender feeds the encoder `BLOCK_LEN - 2` data bits followed by two zero flush bits. The trellis therefore ends in state zero, and only the data bits are delivered. The next block is taken only after every decoded bit of the current block has been handed over.

Top module: `vit_decoder`

## Requirements
- R1: The code is the one produced by an encoder whose state is {previous bit, bit before that}, starting at zero. For input u, symbol bit 1 is u^prev1^prev2 and symbol bit 0 is u^prev2, so input bits 1,1,0,1,1 encode to symbols 2'b11, 2'b01, 2'b01, 2'b00, 2'b01. For error-free symbols the decoded output equals the data bits that were sent.
- R2: Branch metrics are Hamming distances between the received symbol and each branch label. As a result, a block with a single flipped channel bit still decodes to the sent data.
- R3: Each state keeps the smaller of its two candidate sums. A candidate sum is the predecessor metric plus the branch metric, saturated at 2^PM_W-1 (63 by default). On a tie the lower-numbered predecessor wins. The minimum metric over all states never decreases within a block.
- R4: At reset and at the start of every block, state 0's metric is 0 and every other state's metric is 2^PM_W-1.
- R5: Each accepted symbol stores one decision bit per state. The bit is 0 when predecessor {s[0],0} won and 1 when predecessor {s[0],1} won, where s[0] is the low bit of the state's own number. Decoding of noisy blocks matches an independent maximum-likelihood model that uses these rules.
- R6: Traceback starts in state 0 at the final stage and retires one stage per clock. out_valid rises exactly BLOCK_LEN cycles after the edge that accepts the last symbol.
- R7: Exactly BLOCK_LEN-2 bits are delivered per block, earliest data bit first. The two flush bits are not delivered.
- R8: in_ready is high only while a block is being collected. It is low from the last accepted symbol until the edge after the final output handshake. in_valid asserted while in_ready is low has no effect. in_ready and out_valid are never high together.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_bit holds its value.
- R10: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received symbol is present |
| in_ready | output | 1 | Block is accepting symbols |
| in_sym | input | 2 | Hard-decided symbol; bit 1 from taps 111, bit 0 from taps 101 |
| out_valid | output | 1 | Decoded bit is present |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded data bit, in time order |

## Verification
A symbol is taken at the rising edge where in_valid and in_ready are both high. The first decoded bit is due BLOCK_LEN edges after the last symbol's accepting edge. Each further bit is due one edge after the previous handshake. in_ready comes back one edge after the final handshake. The bench drives and samples on falling edges, counts rising edges from the last accept until out_valid is seen, and requires that count to equal BLOCK_LEN. The delivered bits are compared against the sent data and against a bench model of the decoder. That model uses register exchange rather than traceback. During the traceback and emission windows, the bench also keeps in_valid high with junk symbols and stalls out_ready at random, so the ignore and hold rules are exercised.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int CONSTRAINT_LEN = 3;
  localparam int NUM_STATES     = 1 << (CONSTRAINT_LEN - 1);
  localparam int SYM_W          = 2;

  typedef logic [SYM_W-1:0]          sym_t;
  typedef logic [CONSTRAINT_LEN-2:0] state_t;

  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_TRACE   = 2'd1,
    PH_EMIT    = 2'd2
  } phase_t;

  // Symbol expected when leaving state 'pred' with input bit 'u'.
  // pred = {prev1, prev2}; bit1 from taps 111, bit0 from taps 101.
  function automatic sym_t branch_label(input state_t pred, input logic u);
    return {u ^ pred[1] ^ pred[0], u ^ pred[0]};
  endfunction

  // Hamming distance of two 2-bit symbols.
  function automatic logic [1:0] hamming2(input sym_t a, input sym_t b);
    sym_t d;
    d = a ^ b;
    return {1'b0, d[1]} + {1'b0, d[0]};
  endfunction
endpackage

// File: rtl/vit_acs_array.sv
module vit_acs_array
  import vit_pkg::*;
#(
  parameter int PM_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init,
  input  logic                  step,
  input  sym_t                  sym,
  output logic [NUM_STATES-1:0] decisions
);
  localparam logic [PM_W-1:0] PM_MAX = '1;

  function automatic logic [PM_W-1:0] sat_add(input logic [PM_W-1:0] pm,
                                               input logic [1:0] bm);
    logic [PM_W:0] s;
    s = {1'b0, pm} + {{(PM_W-1){1'b0}}, bm};
    return s[PM_W] ? PM_MAX : s[PM_W-1:0];
  endfunction

  logic [PM_W-1:0] pm    [NUM_STATES];
  logic [PM_W-1:0] pm_nx [NUM_STATES];
  logic [PM_W-1:0] min_pm;

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    localparam state_t NS   = state_t'(s);
    localparam state_t P_UP = {NS[0], 1'b0};
    localparam state_t P_LO = {NS[0], 1'b1};
    logic [PM_W-1:0] sum_up, sum_lo;
    assign sum_up       = sat_add(pm[P_UP], hamming2(sym, branch_label(P_UP, NS[1])));
    assign sum_lo       = sat_add(pm[P_LO], hamming2(sym, branch_label(P_LO, NS[1])));
    assign decisions[s] = (sum_lo < sum_up);
    assign pm_nx[s]     = decisions[s] ? sum_lo : sum_up;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      for (int i = 0; i < NUM_STATES; i++) pm[i] <= (i == 0) ? '0 : PM_MAX;
    end else if (step) begin
      for (int i = 0; i < NUM_STATES; i++) pm[i] <= pm_nx[i];
    end
  end

  always_comb begin
    min_pm = pm[0];
    for (int i = 1; i < NUM_STATES; i++) if (pm[i] < min_pm) min_pm = pm[i];
  end

  assert_init_metrics_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (pm[0] == '0 && pm[1] == PM_MAX && pm[2] == PM_MAX && pm[3] == PM_MAX));

  assert_min_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (min_pm >= $past(min_pm)));
endmodule

// File: rtl/vit_surv_mem.sv
module vit_surv_mem
  import vit_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [NUM_STATES-1:0] wdata,
  input  logic [ADDR_W-1:0]     raddr,
  output logic [NUM_STATES-1:0] rdata
);
  logic [NUM_STATES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
  import vit_pkg::*;
#(
  parameter int BLOCK_LEN = 16,
  parameter int ADDR_W    = $clog2(BLOCK_LEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic [NUM_STATES-1:0] rd_data,
  output logic                  busy,
  output logic                  last_step,
  output logic [BLOCK_LEN-1:0]  bits
);
  logic [ADDR_W-1:0] tcnt;
  state_t            tstate;
  logic              surv_bit;
  state_t            trace_pred;

  assign rd_addr    = tcnt;
  assign surv_bit   = rd_data[tstate];
  assign trace_pred = {tstate[0], surv_bit};
  assign last_step  = busy && (tcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tcnt   <= '0;
      tstate <= '0;
      bits   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      tcnt   <= ADDR_W'(BLOCK_LEN - 1);
      tstate <= '0;
    end else if (busy) begin
      bits[tcnt] <= tstate[1];
      tstate     <= trace_pred;
      if (tcnt == '0) busy <= 1'b0;
      else            tcnt <= tcnt - ADDR_W'(1);
    end
  end

  assert_trace_start_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && tstate == '0 && tcnt == ADDR_W'(BLOCK_LEN - 1)));

  assert_trace_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tcnt != '0) |=> (busy && tcnt == $past(tcnt) - ADDR_W'(1)));
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
  import vit_pkg::*;
#(
  parameter int BLOCK_LEN = 16,
  parameter int PM_W      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_sym,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit
);
  localparam int TAIL_LEN  = CONSTRAINT_LEN - 1;
  localparam int DATA_BITS = BLOCK_LEN - TAIL_LEN;
  localparam int ADDR_W    = $clog2(BLOCK_LEN);
  localparam int OUT_W     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  phase_t                phase;
  logic [ADDR_W-1:0]     stage_cnt;
  logic [OUT_W-1:0]      out_cnt;

  // named internal events
  logic                  sym_accept;
  logic                  block_full;
  logic                  emit_fire;
  logic                  emit_last;
  logic                  metrics_init;

  logic [NUM_STATES-1:0] decisions;
  logic [ADDR_W-1:0]     tb_addr;
  logic [NUM_STATES-1:0] tb_data;
  logic                  tb_busy;
  logic                  tb_last_step;
  logic [BLOCK_LEN-1:0]  tb_bits;

  assign in_ready     = (phase == PH_COLLECT);
  assign out_valid    = (phase == PH_EMIT);
  assign sym_accept   = in_valid && in_ready;
  assign block_full   = sym_accept && (stage_cnt == ADDR_W'(BLOCK_LEN - 1));
  assign emit_fire    = out_valid && out_ready;
  assign emit_last    = emit_fire && (out_cnt == OUT_W'(DATA_BITS - 1));
  assign metrics_init = emit_last;
  assign out_bit      = tb_bits[out_cnt];

  vit_acs_array #(.PM_W(PM_W)) u_acs (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (metrics_init),
    .step      (sym_accept),
    .sym       (in_sym),
    .decisions (decisions)
  );

  vit_surv_mem #(.DEPTH(BLOCK_LEN), .ADDR_W(ADDR_W)) u_surv (
    .clk   (clk),
    .we    (sym_accept),
    .waddr (stage_cnt),
    .wdata (decisions),
    .raddr (tb_addr),
    .rdata (tb_data)
  );

  vit_traceback #(.BLOCK_LEN(BLOCK_LEN), .ADDR_W(ADDR_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (block_full),
    .rd_addr   (tb_addr),
    .rd_data   (tb_data),
    .busy      (tb_busy),
    .last_step (tb_last_step),
    .bits      (tb_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_COLLECT;
      stage_cnt <= '0;
      out_cnt   <= '0;
    end else begin
      case (phase)
        PH_COLLECT: if (sym_accept) begin
          if (block_full) begin
            stage_cnt <= '0;
            phase     <= PH_TRACE;
          end else begin
            stage_cnt <= stage_cnt + ADDR_W'(1);
          end
        end
        PH_TRACE: if (tb_last_step) begin
          out_cnt <= '0;
          phase   <= PH_EMIT;
        end
        PH_EMIT: if (emit_fire) begin
          if (emit_last) phase <= PH_COLLECT;
          else           out_cnt <= out_cnt + OUT_W'(1);
        end
        default: phase <= PH_COLLECT;
      endcase
    end
  end

  assert_ready_valid_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_emit_after_trace_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(tb_last_step) && !tb_busy));
endmodule

// File: tb/vit_decoder_tb.sv
module vit_decoder_tb;
  localparam int N    = 16;
  localparam int DATA = N - 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_sym = 2'b00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_bit;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  int data_v [DATA];
  int syms   [N];
  int exp_m  [DATA];
  int got    [DATA];
  int pm_m   [4];
  int npm_m  [4];
  bit path_m  [4][N];
  bit npath_m [4][N];

  always #5 clk = ~clk;

  vit_decoder #(.BLOCK_LEN(N), .PM_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int label_of(input int sr);
    int c0, c1;
    c0 = $countones(sr & 7) % 2;
    c1 = $countones(sr & 5) % 2;
    return c0 * 2 + c1;
  endfunction

  task automatic encode_block();
    int sr = 0;
    for (int t = 0; t < N; t++) begin
      int u = (t < DATA) ? data_v[t] : 0;
      sr = (u << 2) | ((sr >> 1) & 3);
      syms[t] = label_of(sr);
    end
  endtask

  // register-exchange maximum-likelihood model, lower predecessor wins ties
  task automatic model_decode();
    for (int s = 0; s < 4; s++) begin
      pm_m[s] = (s == 0) ? 0 : 63;
      for (int t = 0; t < N; t++) path_m[s][t] = 1'b0;
    end
    for (int t = 0; t < N; t++) begin
      for (int ns = 0; ns < 4; ns++) begin
        int u = ns / 2;
        int p0 = (ns % 2) * 2;
        int p1 = p0 + 1;
        int m0 = pm_m[p0] + $countones(syms[t] ^ label_of(u * 4 + p0));
        int m1 = pm_m[p1] + $countones(syms[t] ^ label_of(u * 4 + p1));
        int w;
        if (m0 > 63) m0 = 63;
        if (m1 > 63) m1 = 63;
        w = (m1 < m0) ? p1 : p0;
        npm_m[ns] = (m1 < m0) ? m1 : m0;
        for (int k = 0; k < N; k++) npath_m[ns][k] = path_m[w][k];
        npath_m[ns][t] = u[0];
      end
      for (int s = 0; s < 4; s++) begin
        pm_m[s] = npm_m[s];
        for (int k = 0; k < N; k++) path_m[s][k] = npath_m[s][k];
      end
    end
    for (int i = 0; i < DATA; i++) exp_m[i] = path_m[0][i];
  endtask

  task automatic run_block(input bit gaps, input bit junk, input bit stalls,
                           input bit clean);
    int i = 0;
    int lat = 0;
    int k = 0;
    int guard = 0;
    bit have_hold = 1'b0;
    int held = 0;
    model_decode();
    while (i < N) begin
      bit acc;
      @(negedge clk);
      in_valid = gaps ? ($urandom % 3 != 0) : 1'b1;
      in_sym   = syms[i][1:0];
      acc = in_valid && in_ready;
      @(posedge clk);
      if (acc) i++;
    end
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      in_valid = junk;
      in_sym   = 2'($urandom);
      if (in_ready) check(1'b0, "R8 in_ready during traceback", 1, 0);
    end while (!out_valid && lat < 200);
    check(lat == N, "R6 latency to first bit", lat, N);
    while (k < DATA && guard < 2000) begin
      guard++;
      out_ready = stalls ? ($urandom % 3 != 0) : 1'b1;
      if (!out_valid) check(1'b0, "R7 out_valid during emission", 0, 1);
      if (in_ready) check(1'b0, "R8 in_ready during emission", 1, 0);
      if (have_hold) check(out_bit == held[0], "R9 held bit", out_bit, held);
      if (out_ready) begin
        got[k] = out_bit;
        k++;
        have_hold = 1'b0;
      end else begin
        held = out_bit;
        have_hold = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = junk;
      in_sym   = 2'($urandom);
    end
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check(!out_valid, "R7 no bit after last data bit", out_valid, 0);
    check(in_ready, "R8 in_ready back after final handshake", in_ready, 1);
    for (int j = 0; j < DATA; j++) begin
      check(got[j] == exp_m[j], "R5 decoded bit vs model", got[j], exp_m[j]);
      if (clean) check(got[j] == data_v[j], "R7 decoded bit vs sent data", got[j], data_v[j]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);

    // R1: worked encoder example, then error-free decode
    for (int j = 0; j < DATA; j++) data_v[j] = 0;
    data_v[0] = 1; data_v[1] = 1; data_v[2] = 0; data_v[3] = 1; data_v[4] = 1;
    encode_block();
    check(syms[0] == 3, "R1 symbol 0", syms[0], 3);
    check(syms[1] == 1, "R1 symbol 1", syms[1], 1);
    check(syms[2] == 1, "R1 symbol 2", syms[2], 1);
    check(syms[3] == 0, "R1 symbol 3", syms[3], 0);
    check(syms[4] == 1, "R1 symbol 4", syms[4], 1);
    run_block(1'b0, 1'b0, 1'b0, 1'b1);

    // R2: one flipped channel bit is corrected
    for (int j = 0; j < DATA; j++) data_v[j] = $urandom % 2;
    encode_block();
    syms[6] = syms[6] ^ 1;
    run_block(1'b1, 1'b0, 1'b0, 1'b1);

    // R8/R9: junk on in_valid while closed, random output stalls, clean data
    for (int j = 0; j < DATA; j++) data_v[j] = $urandom % 2;
    encode_block();
    run_block(1'b1, 1'b1, 1'b1, 1'b1);
    for (int j = 0; j < DATA; j++) data_v[j] = 1;
    encode_block();
    run_block(1'b0, 1'b1, 1'b1, 1'b1);

    // R3/R4/R5: heavy noise, compared with the model only
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < DATA; j++) data_v[j] = $urandom % 2;
      encode_block();
      for (int e = 0; e < 2 + b; e++) begin
        int pos = $urandom % N;
        syms[pos] = syms[pos] ^ (1 << ($urandom % 2));
      end
      run_block(b[0], b[1], 1'b1, 1'b0);
    end

    // R4: fully corrupted block followed by a clean one (metrics restart)
    for (int j = 0; j < DATA; j++) data_v[j] = $urandom % 2;
    encode_block();
    for (int t = 0; t < N; t++) syms[t] = syms[t] ^ 3;
    run_block(1'b0, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < DATA; j++) data_v[j] = (j % 3 == 0) ? 1 : 0;
    encode_block();
    run_block(1'b0, 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule